// File: doc/BRIEF.md
# Virtual Address Translation and Fault Classifier

This block turns a 32-bit virtual address into a physical address for one access per cycle: an instruction fetch, a data read or a data write. Two fixed windows of the address space are never translated. A mid-range window is folded onto the low 512 MB of physical space. The top window is passed through unchanged. Everything else goes either through a flat mapping, when translation is switched off, or through an associative search of a table of translation entries. That search compares the address-space tag and honours four page sizes.

Each accepted request produces one registered response in the following cycle. The response carries either a physical address with its read/write/execute permissions, or a 12-bit fault code. On most faults it also carries a pulse telling the surrounding logic to load the faulting page number into its page-table-entry-high register. The translation entries are inputs to the block. Loading and refilling them is done elsewhere.

The response timing is governed by a two-state machine. ST_IDLE has no result pending. ST_RESP presents a result. The transitions are: accept (ST_IDLE to ST_RESP when `req_valid` is high), stream (ST_RESP stays in ST_RESP when another request arrives), drain (ST_RESP to ST_IDLE when no request arrives) and hold (ST_IDLE stays in ST_IDLE).

Top module: `va_xlate_unit`

## Requirements
- R1: Reset clears `rsp_valid` and `pteh_load`. A request sampled with `req_valid` high on a rising edge gives `rsp_valid` high for the cycle after that edge. A cycle without a request gives `rsp_valid` low in the next cycle.
- R2: An address in 0x80000000..0xBFFFFFFF, accessed in privileged mode, is not translated. It yields `rsp_paddr` = address AND 0x1FFFFFFF, `rsp_perm` = 3'b111 and no fault.
- R3: An address at or above 0xE0000000, in privileged mode, yields `rsp_paddr` equal to the address and `rsp_perm` = 3'b111. The same holds in user mode for addresses in 0xE0000000..0xE3FFFFFF.
- R4: A user-mode access to 0x80000000..0xBFFFFFFF, or to an address at or above 0xE4000000, is an address error. The code is 0x100 for a write and 0x0E0 for a read or a fetch.
- R5: With `mmu_on` low, any other address gives `rsp_paddr` = address AND 0x1FFFFFFF and `rsp_perm` = 3'b111, whatever the entries hold.
- R6: An entry's address-space tag must equal `cur_asid` to match. The exceptions are an entry with its shared bit set, and a privileged access made while `single_space` is high.
- R7: The size code selects the page size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. A valid entry matches when the address lies in [(VPN<<10) aligned down to the page size, that base plus the page size). Invalid entries never match.
- R8: Two or more matching entries give fault code 0x140. This has priority over every other lookup outcome.
- R9: No matching entry gives code 0x060 for a write and 0x040 for a read or a fetch.
- R10: A user-mode access to an entry with protection bit 1 clear gives 0x0C0 for a write and 0x0A0 otherwise. A write to an entry with protection bit 0 clear gives 0x0C0 in either mode.
- R11: A write that passes R10, to an entry whose dirty bit is clear, gives code 0x080.
- R12: `rsp_perm` bit 0 is read, bit 1 is write and bit 2 is execute. On a translated hit: read is 1, execute equals the fetch flag, and write is protection bit 0 AND dirty. On any fault, `rsp_perm` and `rsp_paddr` are zero and `rsp_fault` is 1 (`rsp_code` is 0 when there is no fault).
- R13: On a translated hit, `rsp_paddr` = ((PPN<<10) with the in-page bits cleared) OR (address AND in-page mask).
- R14: `pteh_load` pulses with every faulting response whose code is not 0x140. In that case `pteh_vpn` holds address bits 31:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_write | input | 1 | Access is a data write |
| priv_mode | input | 1 | Privileged mode |
| mmu_on | input | 1 | Translation enabled |
| single_space | input | 1 | Single virtual space mode |
| cur_asid | input | ASID_W | Current address-space tag |
| ent_vpn | input | NUM_ENTRIES*22 | Virtual page numbers, entry i at bits i*22 |
| ent_ppn | input | NUM_ENTRIES*PPN_W | Physical page numbers |
| ent_size | input | NUM_ENTRIES*2 | Page size codes |
| ent_valid | input | NUM_ENTRIES | Valid bits |
| ent_shared | input | NUM_ENTRIES | Shared bits |
| ent_asid | input | NUM_ENTRIES*ASID_W | Entry address-space tags |
| ent_prot | input | NUM_ENTRIES*2 | Protection bits (bit 1 user access, bit 0 writable) |
| ent_dirty | input | NUM_ENTRIES | Dirty bits |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | {execute, write, read} |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 12 | Fault code |
| pteh_load | output | 1 | Load page number into the page-table-entry-high register |
| pteh_vpn | output | 22 | Faulting address bits 31:10 |

## Verification
The bench places two overlapping entries so that a multiple hit and a write to a clean page fall on the same lookup. It also makes a user-mode write hit a page without user access, so that a protection violation and an initial-write condition coincide. The reference model must see the multiple-hit code 0x140 with no page-number load in the first case, and 0x0C0 in the second. Requests are also issued back to back, so that a new acceptance lands in the same cycle as the previous response is shown. Every cycle is compared against the model's queue-free expectation for the request issued one edge earlier.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 10;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int CODE_W     = 12;

    localparam logic [CODE_W-1:0] CODE_NONE       = 12'h000;
    localparam logic [CODE_W-1:0] CODE_MISS_RD    = 12'h040;
    localparam logic [CODE_W-1:0] CODE_MISS_WR    = 12'h060;
    localparam logic [CODE_W-1:0] CODE_FIRST_WR   = 12'h080;
    localparam logic [CODE_W-1:0] CODE_PROT_RD    = 12'h0A0;
    localparam logic [CODE_W-1:0] CODE_PROT_WR    = 12'h0C0;
    localparam logic [CODE_W-1:0] CODE_ADDR_RD    = 12'h0E0;
    localparam logic [CODE_W-1:0] CODE_ADDR_WR    = 12'h100;
    localparam logic [CODE_W-1:0] CODE_MULTI      = 12'h140;

    typedef enum logic [1:0] {
        RG_MAPPED      = 2'd0,
        RG_DIRECT_MASK = 2'd1,
        RG_DIRECT_FLAT = 2'd2
    } region_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } xlt_state_e;

    // In-page offset mask for a size code (1K, 4K, 64K, 1M).
    function automatic logic [VA_W-1:0] page_offset_mask(input logic [1:0] sz);
        logic [VA_W-1:0] m;
        unique case (sz)
            2'd0:    m = 32'h0000_03FF;
            2'd1:    m = 32'h0000_0FFF;
            2'd2:    m = 32'h0000_FFFF;
            default: m = 32'h000F_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/xlt_region_decode.sv
module xlt_region_decode
    import xlt_pkg::*;
(
    input  logic                vaddr_hi_i,
    input  logic [5:0]          vaddr_top_i,
    input  logic                priv_i,
    input  logic                write_i,
    output region_e             region_o,
    output logic                addr_err_o,
    output logic [CODE_W-1:0]   err_code_o
);
    logic user_window;

    always_comb begin
        unique case (vaddr_top_i[5:3])
            3'b100, 3'b101: region_o = RG_DIRECT_MASK;
            3'b111:         region_o = RG_DIRECT_FLAT;
            default:        region_o = RG_MAPPED;
        endcase
    end

    // Only the bottom 64 MB of the top window is open to user mode.
    assign user_window = (vaddr_top_i == 6'b111000) && vaddr_hi_i;

    always_comb begin
        addr_err_o = (region_o != RG_MAPPED) && !priv_i && !user_window;
        err_code_o = addr_err_o ? (write_i ? CODE_ADDR_WR : CODE_ADDR_RD) : CODE_NONE;
    end

endmodule

// File: rtl/xlt_match_array.sv
module xlt_match_array
    import xlt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ASID_W      = 8,
    parameter int PPN_W       = 19
) (
    input  logic [VA_W-1:0]              vaddr_i,
    input  logic                         use_asid_i,
    input  logic [ASID_W-1:0]            cur_asid_i,
    input  logic [NUM_ENTRIES*VPN_W-1:0] ent_vpn_i,
    input  logic [NUM_ENTRIES*PPN_W-1:0] ent_ppn_i,
    input  logic [NUM_ENTRIES*2-1:0]     ent_size_i,
    input  logic [NUM_ENTRIES-1:0]       ent_valid_i,
    input  logic [NUM_ENTRIES-1:0]       ent_shared_i,
    input  logic [NUM_ENTRIES*ASID_W-1:0] ent_asid_i,
    input  logic [NUM_ENTRIES*2-1:0]     ent_prot_i,
    input  logic [NUM_ENTRIES-1:0]       ent_dirty_i,
    output logic                         hit_any_o,
    output logic                         hit_multi_o,
    output logic [PPN_W-1:0]             sel_ppn_o,
    output logic [1:0]                   sel_size_o,
    output logic [1:0]                   sel_prot_o,
    output logic                         sel_dirty_o
);
    localparam logic [NUM_ENTRIES-1:0] ONE = {{(NUM_ENTRIES-1){1'b0}}, 1'b1};

    logic [NUM_ENTRIES-1:0] hits;

    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_ent
        logic [VA_W-1:0] off_mask;
        logic [VA_W-1:0] base;
        logic            tag_ok;
        logic            range_ok;

        assign off_mask = page_offset_mask(ent_size_i[gi*2 +: 2]);
        assign base     = {ent_vpn_i[gi*VPN_W +: VPN_W], {PAGE_SHIFT{1'b0}}};
        assign tag_ok   = ent_shared_i[gi] || !use_asid_i ||
                          (ent_asid_i[gi*ASID_W +: ASID_W] == cur_asid_i);
        assign range_ok = ((vaddr_i & ~off_mask) == (base & ~off_mask));
        assign hits[gi] = ent_valid_i[gi] && tag_ok && range_ok;
    end

    // More than one bit set: clearing the lowest set bit leaves something.
    assign hit_any_o   = |hits;
    assign hit_multi_o = |(hits & (hits - ONE));

    // OR-combine the selected fields; only meaningful for a single hit.
    always_comb begin
        sel_ppn_o   = '0;
        sel_size_o  = '0;
        sel_prot_o  = '0;
        sel_dirty_o = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            sel_ppn_o   = sel_ppn_o  | ({PPN_W{hits[i]}} & ent_ppn_i[i*PPN_W +: PPN_W]);
            sel_size_o  = sel_size_o | ({2{hits[i]}} & ent_size_i[i*2 +: 2]);
            sel_prot_o  = sel_prot_o | ({2{hits[i]}} & ent_prot_i[i*2 +: 2]);
            sel_dirty_o = sel_dirty_o | (hits[i] & ent_dirty_i[i]);
        end
    end

endmodule

// File: rtl/xlt_perm_check.sv
module xlt_perm_check
    import xlt_pkg::*;
#(
    parameter int PPN_W = 19
) (
    input  logic [VA_W-1:0]   vaddr_i,
    input  logic              fetch_i,
    input  logic              write_i,
    input  logic              priv_i,
    input  logic              hit_any_i,
    input  logic              hit_multi_i,
    input  logic [PPN_W-1:0]  sel_ppn_i,
    input  logic [1:0]        sel_size_i,
    input  logic [1:0]        sel_prot_i,
    input  logic              sel_dirty_i,
    output logic              fault_o,
    output logic [CODE_W-1:0] code_o,
    output logic [VA_W-1:0]   paddr_o,
    output logic [2:0]        perm_o
);
    localparam int PAD_W = VA_W - PPN_W - PAGE_SHIFT;

    logic [VA_W-1:0] off_mask;
    logic [VA_W-1:0] frame;

    assign off_mask = page_offset_mask(sel_size_i);
    assign frame    = {{PAD_W{1'b0}}, sel_ppn_i, {PAGE_SHIFT{1'b0}}};

    // Priority: multiple hit, miss, user protection, write protection, clean page.
    always_comb begin
        fault_o = 1'b1;
        code_o  = CODE_NONE;
        paddr_o = '0;
        perm_o  = 3'b000;
        if (hit_multi_i) begin
            code_o = CODE_MULTI;
        end else if (!hit_any_i) begin
            code_o = write_i ? CODE_MISS_WR : CODE_MISS_RD;
        end else if (!priv_i && !sel_prot_i[1]) begin
            code_o = write_i ? CODE_PROT_WR : CODE_PROT_RD;
        end else if (write_i && !sel_prot_i[0]) begin
            code_o = CODE_PROT_WR;
        end else if (write_i && !sel_dirty_i) begin
            code_o = CODE_FIRST_WR;
        end else begin
            fault_o = 1'b0;
            paddr_o = (frame & ~off_mask) | (vaddr_i & off_mask);
            perm_o  = {fetch_i, sel_prot_i[0] & sel_dirty_i, 1'b1};
        end
    end

endmodule

// File: rtl/va_xlate_unit.sv
module va_xlate_unit
    import xlt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ASID_W      = 8,
    parameter int PPN_W       = 19
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [31:0]                   req_vaddr,
    input  logic                          req_fetch,
    input  logic                          req_write,
    input  logic                          priv_mode,
    input  logic                          mmu_on,
    input  logic                          single_space,
    input  logic [ASID_W-1:0]             cur_asid,
    input  logic [NUM_ENTRIES*22-1:0]     ent_vpn,
    input  logic [NUM_ENTRIES*PPN_W-1:0]  ent_ppn,
    input  logic [NUM_ENTRIES*2-1:0]      ent_size,
    input  logic [NUM_ENTRIES-1:0]        ent_valid,
    input  logic [NUM_ENTRIES-1:0]        ent_shared,
    input  logic [NUM_ENTRIES*ASID_W-1:0] ent_asid,
    input  logic [NUM_ENTRIES*2-1:0]      ent_prot,
    input  logic [NUM_ENTRIES-1:0]        ent_dirty,
    output logic                          rsp_valid,
    output logic [31:0]                   rsp_paddr,
    output logic [2:0]                    rsp_perm,
    output logic                          rsp_fault,
    output logic [11:0]                   rsp_code,
    output logic                          pteh_load,
    output logic [21:0]                   pteh_vpn
);
    localparam logic [VA_W-1:0] LOW_MASK = 32'h1FFF_FFFF;

    // ---------------- region classification ----------------
    region_e            region;
    logic               addr_err;
    logic [CODE_W-1:0]  addr_err_code;

    xlt_region_decode u_region (
        .vaddr_hi_i  (req_vaddr[31:26] == 6'b111000),
        .vaddr_top_i (req_vaddr[31:26]),
        .priv_i      (priv_mode),
        .write_i     (req_write),
        .region_o    (region),
        .addr_err_o  (addr_err),
        .err_code_o  (addr_err_code)
    );

    // ---------------- associative lookup ----------------
    logic              use_asid;
    logic              hit_any, hit_multi;
    logic [PPN_W-1:0]  sel_ppn;
    logic [1:0]        sel_size, sel_prot;
    logic              sel_dirty;

    assign use_asid = !(single_space && priv_mode);

    xlt_match_array #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ASID_W      (ASID_W),
        .PPN_W       (PPN_W)
    ) u_match (
        .vaddr_i      (req_vaddr),
        .use_asid_i   (use_asid),
        .cur_asid_i   (cur_asid),
        .ent_vpn_i    (ent_vpn),
        .ent_ppn_i    (ent_ppn),
        .ent_size_i   (ent_size),
        .ent_valid_i  (ent_valid),
        .ent_shared_i (ent_shared),
        .ent_asid_i   (ent_asid),
        .ent_prot_i   (ent_prot),
        .ent_dirty_i  (ent_dirty),
        .hit_any_o    (hit_any),
        .hit_multi_o  (hit_multi),
        .sel_ppn_o    (sel_ppn),
        .sel_size_o   (sel_size),
        .sel_prot_o   (sel_prot),
        .sel_dirty_o  (sel_dirty)
    );

    logic              lk_fault;
    logic [CODE_W-1:0] lk_code;
    logic [VA_W-1:0]   lk_paddr;
    logic [2:0]        lk_perm;

    xlt_perm_check #(.PPN_W(PPN_W)) u_perm (
        .vaddr_i     (req_vaddr),
        .fetch_i     (req_fetch),
        .write_i     (req_write),
        .priv_i      (priv_mode),
        .hit_any_i   (hit_any),
        .hit_multi_i (hit_multi),
        .sel_ppn_i   (sel_ppn),
        .sel_size_i  (sel_size),
        .sel_prot_i  (sel_prot),
        .sel_dirty_i (sel_dirty),
        .fault_o     (lk_fault),
        .code_o      (lk_code),
        .paddr_o     (lk_paddr),
        .perm_o      (lk_perm)
    );

    // ---------------- result selection ----------------
    logic              nx_fault;
    logic [CODE_W-1:0] nx_code;
    logic [VA_W-1:0]   nx_paddr;
    logic [2:0]        nx_perm;

    always_comb begin
        nx_fault = 1'b0;
        nx_code  = CODE_NONE;
        nx_paddr = '0;
        nx_perm  = 3'b111;
        if (addr_err) begin
            nx_fault = 1'b1;
            nx_code  = addr_err_code;
            nx_perm  = 3'b000;
        end else if (region == RG_DIRECT_MASK) begin
            nx_paddr = req_vaddr & LOW_MASK;
        end else if (region == RG_DIRECT_FLAT) begin
            nx_paddr = req_vaddr;
        end else if (!mmu_on) begin
            nx_paddr = req_vaddr & LOW_MASK;
        end else begin
            nx_fault = lk_fault;
            nx_code  = lk_code;
            nx_paddr = lk_paddr;
            nx_perm  = lk_perm;
        end
    end

    // ---------------- response state machine ----------------
    xlt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;   // accept / hold
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;   // stream / drain
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    logic              fault_q;
    logic [CODE_W-1:0] code_q;
    logic [VA_W-1:0]   paddr_q;
    logic [2:0]        perm_q;
    logic              ld_q;
    logic [VPN_W-1:0]  vpn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            code_q  <= CODE_NONE;
            paddr_q <= '0;
            perm_q  <= 3'b000;
            ld_q    <= 1'b0;
            vpn_q   <= '0;
        end else if (req_valid) begin
            fault_q <= nx_fault;
            code_q  <= nx_code;
            paddr_q <= nx_paddr;
            perm_q  <= nx_perm;
            ld_q    <= nx_fault && (nx_code != CODE_MULTI);
            vpn_q   <= req_vaddr[VA_W-1:PAGE_SHIFT];
        end
    end

    always_comb begin
        rsp_valid = (state_q == ST_RESP);
        rsp_fault = fault_q;
        rsp_code  = code_q;
        rsp_paddr = paddr_q;
        rsp_perm  = perm_q;
        pteh_load = rsp_valid && ld_q;
        pteh_vpn  = vpn_q;
    end

    // ---------------- assertions ----------------
    assert_resp_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_direct_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_vaddr[31:30] == 2'b10) && $past(priv_mode))
            |-> (rsp_paddr == {3'b000, $past(req_vaddr[28:0])}));

    assert_first_write_only_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == CODE_FIRST_WR) |-> $past(req_write));

    assert_fault_no_perm_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_perm == 3'b000 && rsp_paddr == '0));

    assert_pteh_load_R14: assert property (@(posedge clk) disable iff (!rst_n)
        pteh_load |-> (rsp_fault && rsp_code != CODE_MULTI));

endmodule

// File: tb/sim_va_xlate_unit.sv
`timescale 1ns/1ps
module sim_va_xlate_unit;
    localparam int N  = 16;
    localparam int AW = 8;
    localparam int PW = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [31:0]   req_vaddr = '0;
    logic          req_fetch = 1'b0, req_write = 1'b0, priv_mode = 1'b0;
    logic          mmu_on = 1'b1, single_space = 1'b0;
    logic [AW-1:0] cur_asid = 8'd5;

    logic [21:0]   b_vpn   [N];
    logic [PW-1:0] b_ppn   [N];
    logic [1:0]    b_size  [N];
    logic          b_valid [N];
    logic          b_shared[N];
    logic [AW-1:0] b_asid  [N];
    logic [1:0]    b_prot  [N];
    logic          b_dirty [N];

    logic [N*22-1:0] ent_vpn;
    logic [N*PW-1:0] ent_ppn;
    logic [N*2-1:0]  ent_size, ent_prot;
    logic [N-1:0]    ent_valid, ent_shared, ent_dirty;
    logic [N*AW-1:0] ent_asid;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_vpn[i*22 +: 22]  = b_vpn[i];
            ent_ppn[i*PW +: PW]  = b_ppn[i];
            ent_size[i*2 +: 2]   = b_size[i];
            ent_prot[i*2 +: 2]   = b_prot[i];
            ent_valid[i]         = b_valid[i];
            ent_shared[i]        = b_shared[i];
            ent_dirty[i]         = b_dirty[i];
            ent_asid[i*AW +: AW] = b_asid[i];
        end
    end

    logic        rsp_valid, rsp_fault, pteh_load;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic [11:0] rsp_code;
    logic [21:0] pteh_vpn;

    va_xlate_unit #(.NUM_ENTRIES(N), .ASID_W(AW), .PPN_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_fetch(req_fetch), .req_write(req_write), .priv_mode(priv_mode),
        .mmu_on(mmu_on), .single_space(single_space), .cur_asid(cur_asid),
        .ent_vpn(ent_vpn), .ent_ppn(ent_ppn), .ent_size(ent_size),
        .ent_valid(ent_valid), .ent_shared(ent_shared), .ent_asid(ent_asid),
        .ent_prot(ent_prot), .ent_dirty(ent_dirty),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
        .rsp_fault(rsp_fault), .rsp_code(rsp_code), .pteh_load(pteh_load),
        .pteh_vpn(pteh_vpn)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Behavioural reference: range arithmetic over integers.
    task automatic model(input logic [31:0] va, input bit fetch, input bit wr, input bit pv,
                         output bit f, output int code, output logic [31:0] pa,
                         output logic [2:0] perm, output bit ld);
        longint v = longint'(va);
        int     nmatch = 0;
        int     idx = 0;
        longint sz, start;
        f = 0; code = 0; pa = 0; perm = 3'b000;
        if ((v >= 64'h8000_0000 && v < 64'hC000_0000) || v >= 64'hE000_0000) begin
            if (!pv && !(v >= 64'hE000_0000 && v < 64'hE400_0000)) begin
                f = 1; code = wr ? 'h100 : 'h0E0;
            end else begin
                pa = (v < 64'hC000_0000) ? (va & 32'h1FFF_FFFF) : va;
                perm = 3'b111;
            end
        end else if (!mmu_on) begin
            pa = va & 32'h1FFF_FFFF; perm = 3'b111;
        end else begin
            for (int i = 0; i < N; i++) begin
                sz = 64'd1024 << ((b_size[i] == 0) ? 0 : (b_size[i] == 1) ? 2 :
                                  (b_size[i] == 2) ? 6 : 10);
                start = (longint'(b_vpn[i]) * 1024) & ~(sz - 1);
                if (b_valid[i] && (b_shared[i] || (single_space && pv) || b_asid[i] == cur_asid)
                    && v >= start && v < start + sz) begin
                    nmatch++; idx = i;
                end
            end
            if (nmatch > 1) begin f = 1; code = 'h140; end
            else if (nmatch == 0) begin f = 1; code = wr ? 'h060 : 'h040; end
            else if (!pv && !b_prot[idx][1]) begin f = 1; code = wr ? 'h0C0 : 'h0A0; end
            else if (wr && !b_prot[idx][0]) begin f = 1; code = 'h0C0; end
            else if (wr && !b_dirty[idx]) begin f = 1; code = 'h080; end
            else begin
                sz = 64'd1024 << ((b_size[idx] == 0) ? 0 : (b_size[idx] == 1) ? 2 :
                                  (b_size[idx] == 2) ? 6 : 10);
                pa = 32'(((longint'(b_ppn[idx]) * 1024) & ~(sz - 1)) | (v & (sz - 1)));
                perm = {fetch, b_prot[idx][0] & b_dirty[idx], 1'b1};
            end
        end
        ld = f && code != 'h140;
    endtask

    // Drive at a falling edge, compare at the next falling edge.
    task automatic apply(input logic [31:0] va, input bit fetch, input bit wr, input bit pv,
                         input string tag);
        bit e_f, e_ld; int e_code; logic [31:0] e_pa; logic [2:0] e_perm;
        req_valid = 1; req_vaddr = va; req_fetch = fetch; req_write = wr; priv_mode = pv;
        model(va, fetch, wr, pv, e_f, e_code, e_pa, e_perm, e_ld);
        @(negedge clk);
        vectors++;
        if (rsp_valid !== 1'b1 || rsp_fault !== e_f || rsp_code !== 12'(e_code) ||
            rsp_paddr !== e_pa || rsp_perm !== e_perm || pteh_load !== e_ld ||
            (e_ld && pteh_vpn !== va[31:10])) begin
            miscompares++;
            $display("FAIL %s va=%08h: got v=%0b f=%0b code=%03h pa=%08h perm=%03b ld=%0b vpn=%06h exp v=1 f=%0b code=%03h pa=%08h perm=%03b ld=%0b vpn=%06h",
                     tag, va, rsp_valid, rsp_fault, rsp_code, rsp_paddr, rsp_perm, pteh_load,
                     pteh_vpn, e_f, 12'(e_code), e_pa, e_perm, e_ld, va[31:10]);
        end
    endtask

    task automatic idle(input string tag);
        req_valid = 0;
        @(negedge clk);
        vectors++;
        if (rsp_valid !== 1'b0 || pteh_load !== 1'b0) begin
            miscompares++;
            $display("FAIL %s idle: got v=%0b ld=%0b exp v=0 ld=0", tag, rsp_valid, pteh_load);
        end
    endtask

    task automatic set_ent(input int i, input logic [31:0] base, input logic [1:0] sz,
                           input logic [PW-1:0] ppn, input logic [AW-1:0] asid, input bit sh,
                           input logic [1:0] prot, input bit dirty, input bit vld);
        b_vpn[i] = base[31:10]; b_size[i] = sz; b_ppn[i] = ppn; b_asid[i] = asid;
        b_shared[i] = sh; b_prot[i] = prot; b_dirty[i] = dirty; b_valid[i] = vld;
    endtask

    initial begin
        for (int i = 0; i < N; i++) set_ent(i, 32'h0, 2'd0, '0, '0, 0, 2'b00, 0, 0);
        set_ent(0, 32'h0040_0000, 2'd1, 19'h01000, 8'd5, 0, 2'b11, 1, 1);
        set_ent(1, 32'h0050_0000, 2'd0, 19'h00155, 8'd9, 1, 2'b10, 1, 1);
        set_ent(2, 32'h1234_5678, 2'd3, 19'h2AB45, 8'd5, 0, 2'b11, 1, 1);
        set_ent(3, 32'h2000_0000, 2'd2, 19'h00400, 8'd5, 0, 2'b00, 0, 1);
        set_ent(4, 32'h3000_0000, 2'd1, 19'h00800, 8'd5, 0, 2'b11, 0, 1);
        set_ent(5, 32'h4000_0000, 2'd2, 19'h01111, 8'd5, 0, 2'b11, 0, 1);
        set_ent(6, 32'h4000_1000, 2'd1, 19'h02222, 8'd5, 1, 2'b11, 0, 1);
        set_ent(7, 32'h5000_0000, 2'd1, 19'h03333, 8'd5, 0, 2'b11, 1, 0);

        repeat (3) @(negedge clk);
        vectors++;
        if (rsp_valid !== 1'b0 || pteh_load !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset: got v=%0b ld=%0b exp v=0 ld=0", rsp_valid, pteh_load);
        end
        rst_n = 1;
        idle("R1");

        // R2 / R3 / R4: fixed regions
        apply(32'h8123_4567, 0, 0, 1, "R2");
        apply(32'hA765_4321, 0, 1, 1, "R2");
        apply(32'hFF00_0010, 0, 1, 1, "R3");
        apply(32'hE100_0000, 0, 1, 0, "R3");
        apply(32'h8000_0000, 0, 0, 0, "R4");
        apply(32'hA000_0000, 0, 1, 0, "R4 R14");
        apply(32'hE400_0000, 1, 0, 0, "R4");
        idle("R1");

        // R5: translation off
        mmu_on = 0;
        apply(32'h1234_5678, 0, 1, 0, "R5");
        apply(32'hC012_3456, 1, 0, 1, "R5");
        apply(32'h4000_1234, 0, 1, 0, "R5");
        mmu_on = 1;

        // R13 / R12 / R6
        apply(32'h0040_0ABC, 0, 0, 0, "R13");
        apply(32'h0040_0000, 1, 0, 0, "R12");
        apply(32'h0040_0FFC, 0, 1, 0, "R12");
        cur_asid = 8'd6;
        apply(32'h0040_0010, 0, 0, 0, "R6");
        single_space = 1;
        apply(32'h0040_0010, 0, 0, 1, "R6");
        apply(32'h0040_0010, 0, 0, 0, "R6");
        single_space = 0;
        apply(32'h0040_0010, 0, 0, 1, "R6");
        cur_asid = 8'd5;
        apply(32'h0050_03FF, 0, 0, 0, "R6");

        // R7: sizes and boundaries
        apply(32'h0050_0400, 0, 0, 0, "R7");
        apply(32'h123F_FFFC, 0, 0, 0, "R7 R13");
        apply(32'h1230_0000, 0, 0, 0, "R7");
        apply(32'h1240_0000, 0, 0, 0, "R7");
        apply(32'h122F_FFFF, 0, 0, 0, "R7");
        apply(32'h2000_FFFF, 0, 0, 1, "R7 R12");
        apply(32'h2001_0000, 0, 0, 1, "R7");

        // R10 / R11
        apply(32'h0050_0004, 0, 1, 0, "R10");
        apply(32'h2000_8000, 0, 0, 0, "R10");
        apply(32'h2000_8000, 0, 1, 0, "R10");
        apply(32'h2000_8000, 0, 1, 1, "R10");
        apply(32'h3000_0FF0, 0, 1, 1, "R11");
        apply(32'h3000_0FF0, 0, 0, 0, "R11 R12");

        // R8: multiple hit beats a clean-page write
        apply(32'h4000_1234, 0, 1, 1, "R8 R14");
        apply(32'h4000_1234, 0, 0, 0, "R8");
        apply(32'h4000_0010, 0, 0, 0, "R8");

        // R9
        apply(32'h5000_0000, 0, 1, 0, "R9");
        apply(32'h5000_0000, 1, 0, 0, "R9");
        apply(32'h7FFF_FFFF, 0, 0, 1, "R9");
        idle("R1");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule